// File: doc/BRIEF.md
# Branch and Skip Address Unit

This block works out where a program counter goes after a conditional control-transfer instruction of an 8-bit-byte, 16-bit-address processor. The sequencer hands it one request at a time: the instruction family, the low nibble of the opcode, the address of the byte that follows the opcode, the one or two bytes already fetched from there, and a snapshot of the condition sources. These are the output flag, a zero indication for the accumulator, the carry flag, external flag lines, the interrupt enable and two pending-interrupt flags. One clock later it returns the next program counter and whether the condition held. When the branch on the counter-interrupt flag is taken, it also returns a one-cycle pulse that tells the timer to clear that flag.

Three families are handled. Short branches replace only the low byte and keep the page. Long branches load a full address or step over it. Long skips step over two bytes or stay put. The interrupt short branches are a variant of the short family. Bit 3 of the nibble inverts the short and long-branch tests. Fetching the bytes and sequencing machine cycles stay outside the block.

Top module: `branch_addr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid`, `taken`, `ci_clear` and `next_pc` become 0, whatever the request inputs carry.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high on the next cycle only. `kind` encodes 0 = short branch, 1 = long branch/skip, 2 = interrupt short branch, 3 = reserved. A reserved request answers with `next_pc = pc_in` and `taken` = 0.
- R3: A taken short or interrupt branch gives `next_pc = {pc_in[15:8], tgt_hi}`. The page is that of the target byte, so an opcode at a page's last location branches into the following page.
- R4: A short or interrupt branch that is not taken gives `next_pc = pc_in + 1`.
- R5: Short-branch tests by nibble: 0 always, 1 `q`, 2 `d_zero`, 3 `df`, 4 to 7 `ext_flags[0]` to `ext_flags[3]`. Nibbles 8 to F test the negation of nibble minus 8, so nibble 8 never branches. `taken` equals the test.
- R6: A taken long branch (nibble bit 2 clear) gives `next_pc = {tgt_hi, tgt_lo}`. A long branch that is not taken gives `pc_in + 2`.
- R7: Long-branch tests: 0 always, 1 `q`, 2 `d_zero`, 3 `df`. Nibbles 9 to B test their negations, and nibble 8 never branches, so it steps over two bytes.
- R8: Long skips (nibble bit 2 set) give `pc_in + 2` when their test holds and `pc_in` otherwise, with `taken` equal to the test. The tests are: 5 `!q`, 6 `!d_zero`, 7 `!df`, C `ie`, D `q`, E `d_zero`, F `df`.
- R9: Long nibble 4 is a no-operation: `next_pc = pc_in`, `taken` = 0.
- R10: Interrupt short branch: nibble E tests `ci` and nibble F tests `xi`. Any other nibble is not taken.
- R11: `ci_clear` pulses high only in the response to a taken interrupt branch with nibble E. A taken branch on `xi` leaves it low.
- R12: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| kind | input | 2 | Instruction family (see R2) |
| op_lo | input | 4 | Opcode low nibble |
| pc_in | input | 16 | Address of the byte after the opcode |
| tgt_hi | input | 8 | First fetched byte |
| tgt_lo | input | 8 | Second fetched byte |
| q | input | 1 | Output flag |
| d_zero | input | 1 | Accumulator equals zero |
| df | input | 1 | Carry flag |
| ext_flags | input | 4 | External flag lines |
| ie | input | 1 | Interrupt enable |
| ci | input | 1 | Counter-interrupt pending |
| xi | input | 1 | External-interrupt pending |
| rsp_valid | output | 1 | Response strobe |
| next_pc | output | 16 | New program counter |
| taken | output | 1 | Condition held |
| ci_clear | output | 1 | Clear pulse for the counter-interrupt flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and four external flag lines. These give a full 16-bit address, so wrap-around at 0xFFFF and page crossings are in reach. Every one of the four flag lines can be selected by a nibble. For each short and long nibble, all 1024 combinations of the ten condition inputs are applied with varied addresses, so each test is seen in both polarities while the other sources take opposing values.

// File: rtl/bau_pkg.sv
// Shared types for the branch and skip address unit.
// Assumes nothing beyond the enumerations below.
package bau_pkg;
    // Instruction family carried on the request.
    typedef enum logic [1:0] {
        BK_SHORT = 2'b00,
        BK_LONG  = 2'b01,
        BK_INTR  = 2'b10,
        BK_NONE  = 2'b11
    } branch_kind_e;

    // How the address generator forms the next program counter.
    typedef enum logic [1:0] {
        AM_PAGE = 2'b00,   // taken: same page, new low byte; else +1
        AM_FULL = 2'b01,   // taken: two-byte target; else +2
        AM_SKIP = 2'b10,   // taken: +2; else unchanged
        AM_HOLD = 2'b11    // unchanged
    } addr_mode_e;
endpackage

// File: rtl/bau_cond_sel.sv
// Condition selector: decodes family and opcode nibble into an address
// mode, evaluates the selected condition and flags a counter-interrupt
// clear. Purely combinational. Assumes 1 <= N_EXT_FLAGS <= 4; missing
// flag lines read as 0.
module bau_cond_sel
    import bau_pkg::*;
#(
    parameter int N_EXT_FLAGS = 4
) (
    input  branch_kind_e           kind,
    input  logic [3:0]             op_lo,
    input  logic                   q,
    input  logic                   d_zero,
    input  logic                   df,
    input  logic [N_EXT_FLAGS-1:0] ext_flags,
    input  logic                   ie,
    input  logic                   ci,
    input  logic                   xi,
    output addr_mode_e             mode,
    output logic                   cond,
    output logic                   ci_clr
);
    localparam int FLAG_SLOTS = 4;

    logic [FLAG_SLOTS-1:0] flag_pad;
    logic [FLAG_SLOTS-1:0] core_tests;
    logic                  core_sel;
    logic                  ext_sel;
    logic                  short_cond;
    logic                  long_cond;
    logic                  intr_cond;

    // Pad the external flag lines to four slots.
    generate
        for (genvar i = 0; i < FLAG_SLOTS; i++) begin : g_pad
            if (i < N_EXT_FLAGS) begin : g_live
                assign flag_pad[i] = ext_flags[i];
            end else begin : g_tied
                assign flag_pad[i] = 1'b0;
            end
        end
    endgenerate

    // Pick the basic tests addressed by the two low nibble bits.
    always_comb begin
        core_tests = {df, d_zero, q, 1'b1};
        core_sel   = core_tests[op_lo[1:0]];
        ext_sel    = flag_pad[op_lo[1:0]];
    end

    // Evaluate the condition for each family.
    always_comb begin
        short_cond = (op_lo[2] ? ext_sel : core_sel) ^ op_lo[3];
        if (!op_lo[2]) begin
            long_cond = core_sel ^ op_lo[3];
        end else if (op_lo[1:0] == 2'b00) begin
            long_cond = op_lo[3] & ie;
        end else begin
            long_cond = core_sel ^ ~op_lo[3];
        end
        case (op_lo)
            4'hE:    intr_cond = ci;
            4'hF:    intr_cond = xi;
            default: intr_cond = 1'b0;
        endcase
    end

    // Route the family to an address mode and a final condition.
    always_comb begin
        ci_clr = 1'b0;
        case (kind)
            BK_SHORT: begin
                mode = AM_PAGE;
                cond = short_cond;
            end
            BK_LONG: begin
                mode = op_lo[2] ? AM_SKIP : AM_FULL;
                cond = long_cond;
            end
            BK_INTR: begin
                mode   = AM_PAGE;
                cond   = intr_cond;
                ci_clr = intr_cond & (op_lo == 4'hE);
            end
            default: begin
                mode = AM_HOLD;
                cond = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bau_addr_gen.sv
// Address generator: forms the next program counter from the current
// one, the fetched bytes, the mode and the condition. Combinational;
// all sums wrap modulo 2^(2*BYTE_W).
module bau_addr_gen
    import bau_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  addr_mode_e            mode,
    input  logic                  cond,
    input  logic [2*BYTE_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0]     tgt_hi,
    input  logic [BYTE_W-1:0]     tgt_lo,
    output logic [2*BYTE_W-1:0]   next_pc
);
    localparam int ADDR_W = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

    logic [ADDR_W-1:0] pc_plus1;
    logic [ADDR_W-1:0] pc_plus2;
    logic [ADDR_W-1:0] page_tgt;
    logic [ADDR_W-1:0] full_tgt;

    // Candidate addresses.
    always_comb begin
        pc_plus1 = pc_in + STEP1;
        pc_plus2 = pc_in + STEP2;
        page_tgt = {pc_in[ADDR_W-1:BYTE_W], tgt_hi};
        full_tgt = {tgt_hi, tgt_lo};
    end

    // Choose the candidate for the mode and condition.
    always_comb begin
        case (mode)
            AM_PAGE: next_pc = cond ? page_tgt : pc_plus1;
            AM_FULL: next_pc = cond ? full_tgt : pc_plus2;
            AM_SKIP: next_pc = cond ? pc_plus2 : pc_in;
            default: next_pc = pc_in;
        endcase
    end
endmodule

// File: rtl/branch_addr_unit.sv
// Branch and skip address unit top. Registers one response per request,
// one cycle after it. Assumes the request inputs are stable in the cycle
// req_valid is high. Synchronous active-low reset.
module branch_addr_unit
    import bau_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int N_EXT_FLAGS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             kind,
    input  logic [3:0]             op_lo,
    input  logic [2*BYTE_W-1:0]    pc_in,
    input  logic [BYTE_W-1:0]      tgt_hi,
    input  logic [BYTE_W-1:0]      tgt_lo,
    input  logic                   q,
    input  logic                   d_zero,
    input  logic                   df,
    input  logic [N_EXT_FLAGS-1:0] ext_flags,
    input  logic                   ie,
    input  logic                   ci,
    input  logic                   xi,
    output logic                   rsp_valid,
    output logic [2*BYTE_W-1:0]    next_pc,
    output logic                   taken,
    output logic                   ci_clear
);
    localparam int ADDR_W = 2 * BYTE_W;

    addr_mode_e        mode_c;
    logic              cond_c;
    logic              clr_c;
    logic [ADDR_W-1:0] npc_c;

    bau_cond_sel #(.N_EXT_FLAGS(N_EXT_FLAGS)) u_cond (
        .kind      (branch_kind_e'(kind)),
        .op_lo     (op_lo),
        .q         (q),
        .d_zero    (d_zero),
        .df        (df),
        .ext_flags (ext_flags),
        .ie        (ie),
        .ci        (ci),
        .xi        (xi),
        .mode      (mode_c),
        .cond      (cond_c),
        .ci_clr    (clr_c)
    );

    bau_addr_gen #(.BYTE_W(BYTE_W)) u_addr (
        .mode    (mode_c),
        .cond    (cond_c),
        .pc_in   (pc_in),
        .tgt_hi  (tgt_hi),
        .tgt_lo  (tgt_lo),
        .next_pc (npc_c)
    );

    // Capture the response; strobes drop when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            ci_clear  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            taken     <= req_valid & cond_c;
            ci_clear  <= req_valid & clr_c;
            if (req_valid) begin
                next_pc <= npc_c;
            end
        end
    end
endmodule

// File: rtl/bau_checker.sv
// Property checker for branch_addr_unit, attached by bind below.
// Observes ports only.
module bau_checker #(
    parameter int BYTE_W      = 8,
    parameter int N_EXT_FLAGS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          kind,
    input logic [3:0]          op_lo,
    input logic [2*BYTE_W-1:0] pc_in,
    input logic [BYTE_W-1:0]   tgt_hi,
    input logic [BYTE_W-1:0]   tgt_lo,
    input logic                rsp_valid,
    input logic [2*BYTE_W-1:0] next_pc,
    input logic                taken,
    input logic                ci_clear
);
    localparam int ADDR_W = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    // R2: a request is answered on the next cycle.
    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: no response without a request.
    p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: taken short branch stays on the target byte's page.
    p_short_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 2'd0) |=>
        (!taken || (next_pc[ADDR_W-1:BYTE_W] == $past(pc_in[ADDR_W-1:BYTE_W])
                    && next_pc[BYTE_W-1:0] == $past(tgt_hi))));

    // R4: not-taken short branch steps by one.
    p_short_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 2'd0) |=> (taken || next_pc == $past(pc_in) + ONE));

    // R6: taken long branch loads both bytes.
    p_long_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 2'd1 && !op_lo[2]) |=>
        (!taken || next_pc == {$past(tgt_hi), $past(tgt_lo)}));

    // R8: long skip moves by two or not at all.
    p_skip_dist_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 2'd1 && op_lo[2]) |=>
        (next_pc == (taken ? $past(pc_in) + TWO : $past(pc_in))));

    // R9: the no-operation nibble is never taken.
    p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 2'd1 && op_lo == 4'h4) |=> !taken);

    // R11: clear pulse only with a taken response.
    p_clear_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ci_clear |-> (rsp_valid && taken));

    // R11: only the counter-interrupt branch may clear.
    p_clear_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(kind == 2'd2 && op_lo == 4'hE)) |=> !ci_clear);
endmodule

bind branch_addr_unit bau_checker #(
    .BYTE_W      (BYTE_W),
    .N_EXT_FLAGS (N_EXT_FLAGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .kind      (kind),
    .op_lo     (op_lo),
    .pc_in     (pc_in),
    .tgt_hi    (tgt_hi),
    .tgt_lo    (tgt_lo),
    .rsp_valid (rsp_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .ci_clear  (ci_clear)
);

// File: tb/branch_addr_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for branch_addr_unit; one task per scenario.
module branch_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  kind = '0;
    logic [3:0]  op_lo = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  tgt_hi = '0;
    logic [7:0]  tgt_lo = '0;
    logic        q = 1'b0, d_zero = 1'b0, df = 1'b0, ie = 1'b0, ci = 1'b0, xi = 1'b0;
    logic [3:0]  ext_flags = '0;
    logic        rsp_valid, taken, ci_clear;
    logic [15:0] next_pc;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    branch_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind),
        .op_lo(op_lo), .pc_in(pc_in), .tgt_hi(tgt_hi), .tgt_lo(tgt_lo),
        .q(q), .d_zero(d_zero), .df(df), .ext_flags(ext_flags), .ie(ie),
        .ci(ci), .xi(xi), .rsp_valid(rsp_valid), .next_pc(next_pc),
        .taken(taken), .ci_clear(ci_clear)
    );

    // Expected response from the requirement tables.
    // f: [0]q [1]d_zero [2]df [6:3]ext_flags [7]ie [8]ci [9]xi
    function automatic void model(input logic [1:0] k, input logic [3:0] op,
                                  input logic [15:0] pc, input logic [7:0] b1,
                                  input logic [7:0] b2, input logic [9:0] f,
                                  output logic [15:0] npc, output logic tk,
                                  output logic clr);
        logic fq, fz, fd, fie, fci, fxi, c;
        logic [3:0] e;
        fq = f[0]; fz = f[1]; fd = f[2]; e = f[6:3]; fie = f[7]; fci = f[8]; fxi = f[9];
        clr = 1'b0;
        c = 1'b0;
        npc = pc;
        if (k == 2'd0) begin
            case (op)
                4'h0: c = 1'b1;   4'h1: c = fq;    4'h2: c = fz;    4'h3: c = fd;
                4'h4: c = e[0];   4'h5: c = e[1];  4'h6: c = e[2];  4'h7: c = e[3];
                4'h8: c = 1'b0;   4'h9: c = !fq;   4'hA: c = !fz;   4'hB: c = !fd;
                4'hC: c = !e[0];  4'hD: c = !e[1]; 4'hE: c = !e[2]; default: c = !e[3];
            endcase
            npc = c ? {pc[15:8], b1} : pc + 16'd1;
        end else if (k == 2'd1) begin
            case (op)
                4'h0: c = 1'b1;  4'h1: c = fq;   4'h2: c = fz;   4'h3: c = fd;
                4'h8: c = 1'b0;  4'h9: c = !fq;  4'hA: c = !fz;  4'hB: c = !fd;
                4'h4: c = 1'b0;  4'h5: c = !fq;  4'h6: c = !fz;  4'h7: c = !fd;
                4'hC: c = fie;   4'hD: c = fq;   4'hE: c = fz;   default: c = fd;
            endcase
            if (op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB})
                npc = c ? {b1, b2} : pc + 16'd2;
            else
                npc = c ? pc + 16'd2 : pc;
        end else if (k == 2'd2) begin
            if (op == 4'hE) begin c = fci; clr = fci; end
            else if (op == 4'hF) c = fxi;
            npc = c ? {pc[15:8], b1} : pc + 16'd1;
        end
        tk = c;
    endfunction

    // Record a check and report a mismatch.
    task automatic check(input string tag, input logic ok, input string got, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %s expected %s", tag, got, exp);
        end
    endtask

    // Issue one request, wait for its response and compare with the model.
    task automatic send(input logic [1:0] k, input logic [3:0] op, input logic [15:0] pc,
                        input logic [7:0] b1, input logic [7:0] b2, input logic [9:0] f,
                        input string tag);
        logic [15:0] enpc;
        logic etk, eclr;
        model(k, op, pc, b1, b2, f, enpc, etk, eclr);
        @(negedge clk);
        req_valid = 1'b1; kind = k; op_lo = op; pc_in = pc; tgt_hi = b1; tgt_lo = b2;
        q = f[0]; d_zero = f[1]; df = f[2]; ext_flags = f[6:3]; ie = f[7]; ci = f[8]; xi = f[9];
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, rsp_valid === 1'b1 && next_pc === enpc && taken === etk && ci_clear === eclr,
              $sformatf("v=%b pc=%h tk=%b clr=%b (k=%0d op=%h)", rsp_valid, next_pc, taken, ci_clear, k, op),
              $sformatf("v=1 pc=%h tk=%b clr=%b", enpc, etk, eclr));
    endtask

    // R1: reset clears every output even with a request present.
    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b1; kind = 2'd1; pc_in = 16'hBEEF;
        repeat (3) @(negedge clk);
        check("R1", rsp_valid === 1'b0 && taken === 1'b0 && ci_clear === 1'b0 && next_pc === 16'h0,
              $sformatf("v=%b pc=%h tk=%b clr=%b", rsp_valid, next_pc, taken, ci_clear),
              "all zero");
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2: one response per request; reserved family holds the address.
    task automatic t_latency();
        send(2'd0, 4'h0, 16'h4000, 8'h21, 8'h00, 10'h0, "R2");
        @(negedge clk);
        check("R2", rsp_valid === 1'b0 && taken === 1'b0,
              $sformatf("v=%b tk=%b", rsp_valid, taken), "v=0 tk=0");
        send(2'd3, 4'h0, 16'h5A5A, 8'h12, 8'h34, 10'h3FF, "R2");
    endtask

    // R3, R4: page handling for short branches, including page crossing.
    task automatic t_short_page();
        send(2'd0, 4'h0, 16'h12FF, 8'h40, 8'h00, 10'h0, "R3");
        send(2'd0, 4'h0, 16'h1300, 8'h40, 8'h00, 10'h0, "R3");
        send(2'd0, 4'h8, 16'h12FF, 8'h40, 8'h00, 10'h0, "R4");
    endtask

    // R5: short-branch tests over every nibble and flag combination.
    task automatic t_short_sweep();
        for (int op = 0; op < 16; op++)
            for (int f = 0; f < 1024; f++)
                send(2'd0, 4'(op), 16'(f * 40503 + op * 257), 8'(f ^ 8'h5C), 8'(f), 10'(f), "R5");
    endtask

    // R6, R7, R8, R9: long branches, skips and the no-operation nibble.
    task automatic t_long_sweep();
        for (int op = 0; op < 16; op++)
            for (int f = 0; f < 1024; f++)
                send(2'd1, 4'(op), 16'(f * 19937 + op * 4099), 8'(f * 3), 8'(f ^ 8'hA3), 10'(f),
                     (op[2] == 1'b0) ? ((op == 0 || op == 8) ? "R7" : "R6")
                                     : ((op == 4) ? "R9" : "R8"));
    endtask

    // R10, R11: interrupt branches and the clear pulse.
    task automatic t_intr();
        for (int op = 0; op < 16; op++)
            for (int f = 0; f < 4; f++)
                send(2'd2, 4'(op), 16'h2A80 + 16'(op), 8'hC3, 8'h00, {f[1], f[0], 8'h00},
                     (op == 14) ? "R11" : "R10");
        send(2'd2, 4'hF, 16'h0100, 8'h77, 8'h00, 10'b1000000000, "R11");
    endtask

    // R12: wrap-around at the top of the address space.
    task automatic t_wrap();
        send(2'd0, 4'h8, 16'hFFFF, 8'h00, 8'h00, 10'h0, "R12");
        send(2'd1, 4'h8, 16'hFFFE, 8'h00, 8'h00, 10'h0, "R12");
        send(2'd1, 4'hD, 16'hFFFF, 8'h00, 8'h00, 10'h1, "R12");
    endtask

    // Stimulus sequence.
    initial begin
        t_reset();
        t_latency();
        t_short_page();
        t_short_sweep();
        t_long_sweep();
        t_intr();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule